// File: doc/BRIEF.md
# Adaptive Dual-Rate Sampling Scheduler

This block decides when a low-power sensing front end is awake. While nothing changes it opens a short awake window once per long slow period and sleeps the rest of the time. As soon as the downstream latch reports that its output has changed, the scheduler moves to a fast rate, where the sleep between windows is a fixed multiple of the window length. Each further change restarts a long quiet timeout. When that timeout runs out with no change, the scheduler drops back to the slow rate.

The block has two inputs from its neighbours. An enable comes from the mode decoder. A one-cycle change pulse comes from the latch. It drives an awake flag, a fast-rate indicator and a strobe in the last cycle of each awake window, which is where the latch takes its sample. Every duration is a cycle-count parameter, so a testbench can shrink the timeout to a few hundred cycles.

Top module: `smp_rate_sched`

## Requirements
- R1: While `rst` is high, and in the cycle after any clock edge that samples `sched_en` low, `awake`, `fast_rate` and `window_end` are all 0.
- R2: After `sched_en` is first sampled high at edge e0, the block is in the slow state. The first awake window starts at edge e0 + (SLOW_PERIOD_CYC − AWAKE_CYC).
- R3: Every awake window keeps `awake` high for exactly AWAKE_CYC cycles. `window_end` is 1 only in the last cycle of a window.
- R4: In the slow state the sleep between windows is SLOW_PERIOD_CYC − AWAKE_CYC cycles, so windows repeat every SLOW_PERIOD_CYC cycles.
- R5: In the fast state the sleep between windows is FAST_MULT × AWAKE_CYC cycles.
- R6: When `out_changed` is sampled high with `sched_en` high, `fast_rate` is 1 from the next cycle on. It stays 1 for exactly TIMEOUT_PERIODS × SLOW_PERIOD_CYC cycles after the last such edge.
- R7: When the timeout expires, `fast_rate` returns to 0. If the block is asleep at that moment, the sleep restarts with the full slow length. If a window is in progress, that window finishes and the sleep after it is slow.
- R8: A change pulse sampled at the edge that closes a window, which is the cycle where `window_end` is high, makes the sleep that follows fast.
- R9: A change pulse sampled at the edge where the timeout would expire keeps `fast_rate` at 1 and restarts the timeout.
- R10: `out_changed` has no effect while `sched_en` is low: `fast_rate` stays 0.
- R11: The sleep length is chosen only when a window closes. A change pulse during a slow sleep does not shorten that sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_en | input | 1 | Scheduling enable from the mode decoder |
| out_changed | input | 1 | One-cycle pulse: the latch output toggled |
| awake | output | 1 | High during an awake window |
| fast_rate | output | 1 | 1 = fast sampling state, 0 = slow |
| window_end | output | 1 | High in the last cycle of an awake window |

## Verification
Two events can land in the same cycle. The first pair is a change pulse and the end of a window: the bench waits for `window_end` and raises `out_changed` in that same cycle. It then expects the next window exactly FAST_MULT × AWAKE_CYC cycles later. The second pair is a change pulse and timeout expiry: the bench times a second pulse to the edge where `fast_rate` would fall. It then expects `fast_rate` to stay high for a full further timeout. Every cycle of these runs is compared against window positions that the bench computes from the period arithmetic.

// File: rtl/smp_sched_pkg.sv
package smp_sched_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SLEEP = 2'd1,
        PH_AWAKE = 2'd2
    } phase_e;

    // Bits needed to hold the values 0 .. n-1
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/smp_return_timer.sv
module smp_return_timer
    import smp_sched_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic chg,
    output logic fast,
    output logic expire,
    output logic fast_nxt
);
    localparam int unsigned RW = cnt_width(TIMEOUT_CYC);
    localparam logic [RW-1:0] RELOAD = RW'(TIMEOUT_CYC - 1);

    logic [RW-1:0] remain;
    logic          fast_q;

    // expiry is blocked by a change pulse in the same cycle
    assign expire   = en && fast_q && (remain == '0) && !chg;
    assign fast_nxt = en && (chg || (fast_q && !expire));
    assign fast     = fast_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            fast_q <= 1'b0;
            remain <= '0;
        end else if (chg) begin
            fast_q <= 1'b1;
            remain <= RELOAD;
        end else if (fast_q) begin
            if (remain == '0) fast_q <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

endmodule

// File: rtl/smp_window_timer.sv
module smp_window_timer
    import smp_sched_pkg::*;
#(
    parameter int unsigned AWAKE_CYC      = 4,
    parameter int unsigned SLOW_SLEEP_CYC = 100,
    parameter int unsigned FAST_SLEEP_CYC = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic fast_nxt,
    input  logic expire,
    output logic awake,
    output logic done
);
    localparam int unsigned CW = cnt_width(max3(AWAKE_CYC, SLOW_SLEEP_CYC, FAST_SLEEP_CYC));
    localparam logic [CW-1:0] LD_AWAKE = CW'(AWAKE_CYC - 1);
    localparam logic [CW-1:0] LD_SLOW  = CW'(SLOW_SLEEP_CYC - 1);
    localparam logic [CW-1:0] LD_FAST  = CW'(FAST_SLEEP_CYC - 1);

    phase_e        ph;
    logic [CW-1:0] cnt;

    assign awake = (ph == PH_AWAKE);
    assign done  = awake && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ph  <= PH_IDLE;
            cnt <= LD_SLOW;
        end else begin
            case (ph)
                PH_IDLE: ph <= PH_SLEEP;
                PH_SLEEP: begin
                    if (expire) begin
                        cnt <= LD_SLOW;
                    end else if (cnt == '0) begin
                        ph  <= PH_AWAKE;
                        cnt <= LD_AWAKE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_AWAKE: begin
                    if (cnt == '0) begin
                        ph  <= PH_SLEEP;
                        cnt <= fast_nxt ? LD_FAST : LD_SLOW;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/smp_rate_sched.sv
module smp_rate_sched
    import smp_sched_pkg::*;
#(
    parameter int unsigned AWAKE_CYC       = 5000,
    parameter int unsigned SLOW_PERIOD_CYC = 5600000,
    parameter int unsigned FAST_MULT       = 8,
    parameter int unsigned TIMEOUT_PERIODS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic sched_en,
    input  logic out_changed,
    output logic awake,
    output logic fast_rate,
    output logic window_end
);
    localparam int unsigned SLOW_SLEEP_CYC = SLOW_PERIOD_CYC - AWAKE_CYC;
    localparam int unsigned FAST_SLEEP_CYC = FAST_MULT * AWAKE_CYC;
    localparam int unsigned TIMEOUT_CYC    = TIMEOUT_PERIODS * SLOW_PERIOD_CYC;

    logic expire;
    logic fast_nxt;

    smp_return_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_ret (
        .clk      (clk),
        .rst      (rst),
        .en       (sched_en),
        .chg      (out_changed),
        .fast     (fast_rate),
        .expire   (expire),
        .fast_nxt (fast_nxt)
    );

    smp_window_timer #(
        .AWAKE_CYC      (AWAKE_CYC),
        .SLOW_SLEEP_CYC (SLOW_SLEEP_CYC),
        .FAST_SLEEP_CYC (FAST_SLEEP_CYC)
    ) u_win (
        .clk      (clk),
        .rst      (rst),
        .en       (sched_en),
        .fast_nxt (fast_nxt),
        .expire   (expire),
        .awake    (awake),
        .done     (window_end)
    );

endmodule

// File: rtl/smp_rate_sched_chk.sv
module smp_rate_sched_chk #(
    parameter int unsigned AWAKE_CYC = 5000
) (
    input logic clk,
    input logic rst,
    input logic sched_en,
    input logic out_changed,
    input logic awake,
    input logic fast_rate,
    input logic window_end
);
    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)        run_len <= '0;
        else if (awake) run_len <= run_len + 1'b1;
        else            run_len <= '0;
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sched_en |=> (!awake && !fast_rate && !window_end)); // R1

    AST_AWAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        awake |-> $past(sched_en)); // R2

    AST_STROBE_INSIDE: assert property (@(posedge clk) disable iff (rst)
        window_end |-> awake); // R3

    AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (rst)
        awake |-> (run_len < 32'(AWAKE_CYC))); // R3

    AST_SLEEP_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        window_end |=> !awake); // R4

    AST_CHG_FAST: assert property (@(posedge clk) disable iff (rst)
        (sched_en && out_changed) |=> fast_rate); // R6

    AST_DROP_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($fell(fast_rate) && $past(sched_en)) |-> !$past(out_changed)); // R9

endmodule

bind smp_rate_sched smp_rate_sched_chk #(
    .AWAKE_CYC (AWAKE_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sched_en    (sched_en),
    .out_changed (out_changed),
    .awake       (awake),
    .fast_rate   (fast_rate),
    .window_end  (window_end)
);

// File: tb/smp_rate_sched_test.sv
`timescale 1ns/100ps
module smp_rate_sched_test;
    localparam int A  = 3;
    localparam int P  = 40;
    localparam int M  = 8;
    localparam int TP = 4;
    localparam int L  = P - A;   // slow sleep
    localparam int F  = M * A;   // fast sleep
    localparam int Q  = A + F;   // fast period
    localparam int T  = TP * P;  // timeout

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sched_en = 1'b0;
    logic out_changed = 1'b0;
    logic awake, fast_rate, window_end;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    smp_rate_sched #(
        .AWAKE_CYC       (A),
        .SLOW_PERIOD_CYC (P),
        .FAST_MULT       (M),
        .TIMEOUT_PERIODS (TP)
    ) uut (
        .clk         (clk),
        .rst         (rst),
        .sched_en    (sched_en),
        .out_changed (out_changed),
        .awake       (awake),
        .fast_rate   (fast_rate),
        .window_end  (window_end)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_end(input string req);
        int guard = 0;
        while (!window_end && guard < 400) begin
            step();
            guard++;
        end
        chk(window_end, req, window_end, 1);
    endtask

    // slow pattern, j edges after a slow sleep load
    function automatic int slow_aw(input int j);
        return (j >= L && ((j - L) % P) < A) ? 1 : 0;
    endfunction
    function automatic int slow_dn(input int j);
        return (j >= L && ((j - L) % P) == A - 1) ? 1 : 0;
    endfunction

    // pattern after fast sleeping starts at edge fs, timeout expires at edge e
    function automatic int fast_base(input int fs, input int e);
        int r;
        r = (e - 1 - fs) % Q;
        return (r >= F) ? fs + ((e - 1 - fs) / Q + 1) * Q : e;
    endfunction
    function automatic int adapt_aw(input int k, input int fs, input int e);
        int b;
        b = fast_base(fs, e);
        if (k < b) return (((k - fs) % Q) >= F) ? 1 : 0;
        return slow_aw(k - b);
    endfunction
    function automatic int adapt_dn(input int k, input int fs, input int e);
        int b;
        b = fast_base(fs, e);
        if (k < b) return (((k - fs) % Q) == Q - 1) ? 1 : 0;
        return slow_dn(k - b);
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // reset state
        step(); step();
        chk(!awake && !fast_rate && !window_end, "R1 reset", {awake, fast_rate, window_end}, 0);
        rst = 1'b0;
        step();
        chk(!awake && !fast_rate, "R1 disabled", {awake, fast_rate}, 0);

        // slow sweep from enable
        sched_en = 1'b1;
        step();                                    // edge k=0
        for (int k = 0; k < 3 * P; k++) begin
            chk(awake == slow_aw(k), "R2/R4 slow awake", awake, slow_aw(k));
            chk(window_end == slow_dn(k), "R3 slow strobe", window_end, slow_dn(k));
            chk(!fast_rate, "R4 slow state", fast_rate, 0);
            step();
        end

        // change pulse together with window end
        wait_end("R8 find end");
        out_changed = 1'b1;
        step();                                    // edge k=0
        out_changed = 1'b0;
        for (int k = 0; k < T + 2 * P; k++) begin
            chk(fast_rate == (k < T), "R6 fast hold", fast_rate, int'(k < T));
            chk(awake == adapt_aw(k, 0, T), "R5/R8 awake", awake, adapt_aw(k, 0, T));
            chk(window_end == adapt_dn(k, 0, T), "R7 strobe", window_end, adapt_dn(k, 0, T));
            step();
        end

        // change pulse in the middle of a slow sleep; expiry lands in sleep
        wait_end("R11 find end");
        step();                                    // edge k=0, slow sleep loaded
        for (int k = 1; k < 5; k++) step();
        out_changed = 1'b1;
        step();                                    // edge k=5
        out_changed = 1'b0;
        for (int k = 5; k < 5 + T + 2 * P; k++) begin
            int ea, ed;
            if (k < L + A) begin
                ea = slow_aw(k);
                ed = slow_dn(k);
            end else begin
                ea = adapt_aw(k, L + A, 5 + T);
                ed = adapt_dn(k, L + A, 5 + T);
            end
            chk(awake == ea, "R11/R7 awake", awake, ea);
            chk(window_end == ed, "R7 strobe", window_end, ed);
            chk(fast_rate == (k < 5 + T), "R6 fast hold", fast_rate, int'(k < 5 + T));
            step();
        end

        // change pulse on the expiry edge
        out_changed = 1'b1;
        step();                                    // edge 0
        out_changed = 1'b0;
        for (int k = 1; k < T; k++) step();        // now after edge T-1
        chk(fast_rate, "R6 before expiry", fast_rate, 1);
        out_changed = 1'b1;
        step();                                    // edge T
        out_changed = 1'b0;
        chk(fast_rate, "R9 held at expiry", fast_rate, 1);
        for (int k = T + 1; k < 2 * T; k++) step();
        chk(fast_rate, "R9 restarted timeout", fast_rate, 1);
        step();                                    // edge 2T
        chk(!fast_rate, "R9 second expiry", fast_rate, 0);

        // disable mid-window, change pulses while disabled
        out_changed = 1'b1;
        step();
        out_changed = 1'b0;
        while (!awake) step();
        sched_en = 1'b0;
        step();
        chk(!awake && !fast_rate && !window_end, "R1 disable", {awake, fast_rate, window_end}, 0);
        for (int k = 0; k < 6; k++) begin
            out_changed = 1'b1;
            step();
            chk(!fast_rate, "R10 ignored pulse", fast_rate, 0);
            chk(!awake, "R10 stays asleep", awake, 0);
        end
        out_changed = 1'b0;
        sched_en = 1'b1;
        step();                                    // edge k=0
        for (int k = 0; k <= L; k++) begin
            chk(awake == (k == L), "R2 re-enable start", awake, int'(k == L));
            chk(!fast_rate, "R2 slow on entry", fast_rate, 0);
            step();
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule